// File: doc/BRIEF.md
# Receive Alarm Status Register

This block holds the receive-side alarm byte of a serial link disassembler. It watches three lock indicators (descrambler, transport-container delineation and frame delineation) and the received link-label byte, which it compares against a programmable expected label. It records each alarm condition in a sticky bit. A processor read of the register clears the sticky bits. A flag from a separate mailbox block supplies bit 0, and bit 7 is reserved.

The read value is a combinational view of the stored bits, so a processor sees the current state on the same cycle it selects the register. A per-bit enable mask gates a single level interrupt request. The interrupt is registered, so it follows the register contents by one clock.

Top module: `rx_alarm_reg`

## Requirements
- R1: After reset, with all inputs at zero, the read value is 0x00 and `irq_o` is 0.
- R2: Bit 7 of `rd_data_o` always reads 0.
- R3: Bit 0 of `rd_data_o` equals `mbox_full_i` in the same cycle. A register read has no effect on it.
- R4: Bits 3, 2 and 1 hold the descrambler, container-delineation and frame-delineation loss-of-lock alarms. Each input uses 1 for out of lock. A 1 sampled at a clock edge sets the bit from that edge onward, and the bit stays set until a read clears it.
- R5: Bit 5 (label mismatch) sets at any edge where `rx_label_i` differs from `exp_label_i`.
- R6: Bit 6 (label change) sets at any edge where `rx_label_i` differs from the label stored at the previous edge. The stored label resets to 0.
- R7: Bit 4 (change of status) sets at any edge where the three loss-of-lock inputs differ from their values at the previous edge. Those stored values reset to 0.
- R8: An edge with `rd_stb_i` and `rd_sel_i` both high clears bits 6..1. A bit whose set condition is present at that same edge stays or becomes 1. `rd_stb_i` alone, without `rd_sel_i`, changes nothing.
- R9: `irq_o` at the edge after edge t equals the OR over bits of (read value AND `irq_en_i`) sampled at edge t. It therefore drops one cycle after the last enabled bit clears.
- R10: With an enable mask of zero, `irq_o` stays 0 regardless of the alarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lol_descr_i | input | 1 | Descrambler out of lock (1 = out of lock) |
| lol_cont_i | input | 1 | Transport-container delineation out of lock |
| lol_frame_i | input | 1 | Frame delineation out of lock |
| rx_label_i | input | LBL_W | Received link label |
| exp_label_i | input | LBL_W | Programmed expected link label |
| rd_stb_i | input | 1 | Processor read strobe |
| rd_sel_i | input | 1 | Register selected by address decode |
| irq_en_i | input | 8 | Per-bit interrupt enable mask |
| mbox_full_i | input | 1 | Mailbox-full flag from the mailbox block |
| rd_data_o | output | 8 | Register read value |
| irq_o | output | 1 | Level interrupt request |

## Verification
A clear-on-read and a new alarm event can land on the same clock edge. The event must win. The bench provokes this by raising the frame loss-of-lock input, and separately changing the received label, in the exact cycle that carries the selected read strobe. It then judges the byte read one cycle later against the expected set bits, including the change-of-status bit that the lock transition adds. Sweeps over every pair of old and new lock states also read the register immediately after a clear. This confirms that conditions still active survive while the derived change bit is gone.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
   localparam int REG_W     = 8;
   localparam int N_LOL     = 3;
   localparam int B_MBOX    = 0;
   localparam int B_LOL_FRM = 1;
   localparam int B_LOL_CNT = 2;
   localparam int B_LOL_DSC = 3;
   localparam int B_COS     = 4;
   localparam int B_MISM    = 5;
   localparam int B_LCHG    = 6;
   localparam int B_RSV     = 7;
   localparam int N_STICKY  = B_LCHG - B_LOL_FRM + 1;
endpackage

// File: rtl/rxa_sticky.sv
module rxa_sticky #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= set_i | (q & {W{~clr_i}});
   end

   assign q_o = q;
endmodule

// File: rtl/rxa_change_det.sv
module rxa_change_det #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic         chg_o
);
   logic [W-1:0] prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= '0;
      else        prev <= d_i;
   end

   assign chg_o = (d_i != prev);
endmodule

// File: rtl/rxa_irq.sv
module rxa_irq #(
   parameter int W          = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   logic any_en;
   assign any_en = |(stat_i & en_i);

   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_en;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         assign irq_o = any_en;
      end
   endgenerate
endmodule

// File: rtl/rx_alarm_reg.sv
module rx_alarm_reg #(
   parameter int LBL_W          = 8,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lol_descr_i,
   input  logic             lol_cont_i,
   input  logic             lol_frame_i,
   input  logic [LBL_W-1:0] rx_label_i,
   input  logic [LBL_W-1:0] exp_label_i,
   input  logic             rd_stb_i,
   input  logic             rd_sel_i,
   input  logic [7:0]       irq_en_i,
   input  logic             mbox_full_i,
   output logic [7:0]       rd_data_o,
   output logic             irq_o
);
   import rxa_pkg::*;

   generate
      if (LBL_W < 1 || LBL_W > 32) begin : g_bad_lbl
         $error("rx_alarm_reg: LBL_W must be 1..32");
      end
      if (REG_W != 8) begin : g_bad_reg
         $error("rx_alarm_reg: register width must be 8");
      end
   endgenerate

   logic [N_LOL-1:0]    lol_vec;
   logic                lol_chg;
   logic                lbl_chg;
   logic                lbl_mism;
   logic                rd_clr;
   logic [N_STICKY-1:0] ev;
   logic [N_STICKY-1:0] sticky;
   logic [REG_W-1:0]    rd_val;

   // lol_vec order follows register bits 3..1
   assign lol_vec  = {lol_descr_i, lol_cont_i, lol_frame_i};
   assign lbl_mism = (rx_label_i != exp_label_i);
   assign rd_clr   = rd_stb_i & rd_sel_i;

   rxa_change_det #(.W(N_LOL)) u_lol_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lol_vec),
      .chg_o (lol_chg)
   );

   rxa_change_det #(.W(LBL_W)) u_lbl_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_label_i),
      .chg_o (lbl_chg)
   );

   // event vector packed as register bits 6..1
   assign ev = {lbl_chg, lbl_mism, lol_chg, lol_vec};

   rxa_sticky #(.W(N_STICKY)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev),
      .clr_i (rd_clr),
      .q_o   (sticky)
   );

   always_comb begin
      rd_val                     = '0;
      rd_val[B_LCHG:B_LOL_FRM]   = sticky;
      rd_val[B_MBOX]             = mbox_full_i;
      rd_val[B_RSV]              = 1'b0;
   end

   assign rd_data_o = rd_val;

   rxa_irq #(.W(REG_W), .REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (rd_val),
      .en_i   (irq_en_i),
      .irq_o  (irq_o)
   );
endmodule

// File: rtl/rxa_chk.sv
module rxa_chk #(
   parameter int LBL_W          = 8,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lol_descr_i,
   input logic             lol_cont_i,
   input logic             lol_frame_i,
   input logic [LBL_W-1:0] rx_label_i,
   input logic [LBL_W-1:0] exp_label_i,
   input logic             rd_stb_i,
   input logic             rd_sel_i,
   input logic [7:0]       irq_en_i,
   input logic             mbox_full_i,
   input logic [7:0]       rd_data_o,
   input logic             irq_o
);
   always @(posedge clk) begin
      if (rst_n) begin
         a_r2_rsv_zero: assert (rd_data_o[7] == 1'b0);
         a_r3_mbox_pass: assert (rd_data_o[0] == mbox_full_i);
      end
   end

   a_r4_descr_sets: assert property (@(posedge clk) disable iff (!rst_n)
      lol_descr_i |=> rd_data_o[3]);

   a_r4_cont_sets: assert property (@(posedge clk) disable iff (!rst_n)
      lol_cont_i |=> rd_data_o[2]);

   a_r5_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_label_i != exp_label_i) |=> rd_data_o[5]);

   a_r8_clear_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && rd_sel_i && !lol_frame_i) |=> !rd_data_o[1]);

   a_r8_hold_unsel: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_sel_i && rd_data_o[6]) |=> rd_data_o[6]);

   generate
      if (IRQ_REGISTERED) begin : g_irq_chk
         a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
            (|(rd_data_o & irq_en_i)) |=> irq_o);
         a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(rd_data_o & irq_en_i)) |=> !irq_o);
      end
   endgenerate
endmodule

bind rx_alarm_reg rxa_chk #(.LBL_W(LBL_W), .IRQ_REGISTERED(IRQ_REGISTERED)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lol_descr_i (lol_descr_i),
   .lol_cont_i  (lol_cont_i),
   .lol_frame_i (lol_frame_i),
   .rx_label_i  (rx_label_i),
   .exp_label_i (exp_label_i),
   .rd_stb_i    (rd_stb_i),
   .rd_sel_i    (rd_sel_i),
   .irq_en_i    (irq_en_i),
   .mbox_full_i (mbox_full_i),
   .rd_data_o   (rd_data_o),
   .irq_o       (irq_o)
);

// File: tb/tb_rx_alarm_reg.sv
`timescale 1ns/1ps
module tb_rx_alarm_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] lol = 3'b000;
   logic [7:0] rx_lbl = 8'h00;
   logic [7:0] exp_lbl = 8'h00;
   logic       rd_stb = 1'b0;
   logic       rd_sel = 1'b0;
   logic [7:0] irq_en = 8'h00;
   logic       mb = 1'b0;
   logic [7:0] rd_data;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rx_alarm_reg dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .lol_descr_i (lol[2]),
      .lol_cont_i  (lol[1]),
      .lol_frame_i (lol[0]),
      .rx_label_i  (rx_lbl),
      .exp_label_i (exp_lbl),
      .rd_stb_i    (rd_stb),
      .rd_sel_i    (rd_sel),
      .irq_en_i    (irq_en),
      .mbox_full_i (mb),
      .rd_data_o   (rd_data),
      .irq_o       (irq)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic clr_rd();
      rd_stb = 1'b1; rd_sel = 1'b1;
      step();
      rd_stb = 1'b0; rd_sel = 1'b0;
   endtask

   task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mk(logic lc, logic mm, logic cs, logic [2:0] lv, logic m0);
      return {1'b0, lc, mm, cs, lv, m0};
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #1;
      step(); step(); step();
      // R1: reset state
      chk8("R1 rd during reset", rd_data, 8'h00);
      chk8("R1 irq during reset", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;
      step();
      chk8("R1 rd after reset", rd_data, 8'h00);
      chk8("R1 irq after reset", {7'd0, irq}, 8'h00);

      // R4 R7 R8 R2: all pairs of lock states
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            lol = a[2:0];
            step();
            clr_rd();
            chk8("R8 active lol survives clear", rd_data, mk(1'b0, 1'b0, 1'b0, a[2:0], 1'b0));
            lol = b[2:0];
            step();
            chk8("R4 R7 lol transition", rd_data,
                 mk(1'b0, 1'b0, (a != b), a[2:0] | b[2:0], 1'b0));
         end
      end
      lol = 3'b000;
      step();
      clr_rd();

      // R5 R6: label sweep
      for (int ei = 0; ei < 4; ei++) begin
         for (int xi = 0; xi < 4; xi++) begin
            for (int yi = 0; yi < 4; yi++) begin
               logic [7:0] vals [4];
               vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h80; vals[3] = 8'hFF;
               exp_lbl = vals[ei];
               rx_lbl  = vals[xi];
               step();
               clr_rd();
               rx_lbl = vals[yi];
               step();
               chk8("R5 R6 label compare", rd_data,
                    mk(vals[xi] != vals[yi],
                       (vals[xi] != exp_lbl) || (vals[yi] != exp_lbl),
                       1'b0, 3'b000, 1'b0));
            end
         end
      end

      // R8: event in same cycle as clearing read
      exp_lbl = 8'h05; rx_lbl = 8'h05; lol = 3'b000;
      step();
      clr_rd();
      chk8("R8 clean before collision", rd_data, 8'h00);
      rd_stb = 1'b1; rd_sel = 1'b1; lol = 3'b001;
      step();
      rd_stb = 1'b0; rd_sel = 1'b0;
      chk8("R8 lol event kept on read", rd_data, mk(1'b0, 1'b0, 1'b1, 3'b001, 1'b0));
      lol = 3'b000;
      step();
      clr_rd();
      chk8("R8 clear after collision", rd_data, 8'h00);
      rd_stb = 1'b1; rd_sel = 1'b1; rx_lbl = 8'h06;
      step();
      rd_stb = 1'b0; rd_sel = 1'b0;
      chk8("R8 R6 label event kept on read", rd_data, mk(1'b1, 1'b1, 1'b0, 3'b000, 1'b0));
      rd_stb = 1'b1; rd_sel = 1'b0;
      step();
      rd_stb = 1'b0;
      chk8("R8 strobe without select ignored", rd_data, mk(1'b1, 1'b1, 1'b0, 3'b000, 1'b0));

      // R3: mailbox bit passthrough
      rx_lbl = 8'h05;
      step();
      clr_rd();
      mb = 1'b1;
      #1;
      chk8("R3 mbox bit same cycle", rd_data, 8'h01);
      clr_rd();
      chk8("R3 mbox unaffected by read", rd_data, 8'h01);
      irq_en = 8'h01;
      step(); step();
      chk8("R9 mbox irq", {7'd0, irq}, 8'h01);
      mb = 1'b0;
      step(); step();
      chk8("R9 mbox irq drop", {7'd0, irq}, 8'h00);

      // R9 R10: enable mask sweep
      for (int en = 0; en < 256; en++) begin
         irq_en = en[7:0];
         lol = 3'b100;
         step();
         lol = 3'b000;
         step();
         chk8("R9 R10 irq vs mask", {7'd0, irq}, {7'd0, |(en[7:0] & 8'h18)});
         clr_rd();
         step();
         chk8("R9 irq drops after clear", {7'd0, irq}, 8'h00);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule